// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Override

This block is one general-purpose I/O port on a simple register bus. Software programs a direction bit and an output latch bit for each pin. The pad levels enter through a two-flop synchronizer and are read back through a read mux. Two peripherals can take a pin away from software control. The first is a motor-PWM generator, which has one enable and one value per pin. The second is a timer, which has one output-compare enable and one compare value per even pin.

The effective direction of each pin is resolved by priority. An active PWM enable always makes the pin an output, and the PWM value drives it. Failing that, on an even pin an active timer compare enable makes the pin an output, and the compare value drives it. Only when neither peripheral claims the pin does the software direction bit decide, and the latch then drives the pin. The bus is single-cycle. A write is taken at the clock edge while the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction register and the output latch hold 0x00. With no peripheral enable active, `pad_oe` and `pad_out` are then 0x00.
- R2: The direction register is at BASE+2 (0x0292 by default). It can be written and read back at any time.
- R3: With no peripheral enable on pin i, `pad_oe[i]` equals direction bit i (1 = output, 0 = input). When the pin is an output, `pad_out[i]` equals latch bit i.
- R4: When `pwm_en[i]` is 1, pin i is an output driven by `pwm_val[i]`. This holds on every pin, whatever the direction bit and timer enable hold.
- R5: On even pin 2k, when `pwm_en[2k]` is 0 and `tmr_oc_en[k]` is 1, the pin is an output driven by `tmr_oc_val[k]`. Odd pins never respond to the timer.
- R6: A read of the data register at BASE+0 returns, per bit, the latch bit for pins whose effective direction is output, and the synchronized pad level for input pins. Writes to BASE+0 load the latch.
- R7: A read of the input register at BASE+1 always returns the synchronized pad levels, whatever the pin directions.
- R8: A change on `pad_in` becomes visible in bus reads after exactly two clock edges. After only one edge the old level is still read.
- R9: The reserved location BASE+3 always reads 0x00. A write to it leaves the direction register and the latch unchanged.
- R10: Addresses outside BASE..BASE+3 read 0x00. Writes to them change no register.
- R11: The latch takes writes while a pin is an input. The written value appears on `pad_out` as soon as the pin becomes an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Raw pad input levels |
| pwm_en | input | 8 | Per-pin motor-PWM enable |
| pwm_val | input | 8 | Per-pin motor-PWM output value |
| tmr_oc_en | input | 4 | Timer output-compare enable, channel k serves pin 2k |
| tmr_oc_val | input | 4 | Timer compare output value, channel k serves pin 2k |
| pad_oe | output | 8 | Per-pin output enable toward the pad |
| pad_out | output | 8 | Per-pin output value toward the pad |

## Verification
The bench uses the default parameters: eight pins, a 16-bit address and base 0x0290. This puts all four timer channels and all four odd pins within reach, so the even/odd split of the override can be seen on each pin. Random mixes of PWM enables, timer enables, direction bits and pad levels exercise every branch of the priority chain. Directed steps pin down the two-edge synchronizer delay, the reserved and unmapped locations, and the latch value that a pin carries when it turns from input to output.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    // register offsets from the port base (two low address bits)
    localparam logic [1:0] OFS_DATA  = 2'd0;
    localparam logic [1:0] OFS_INPUT = 2'd1;
    localparam logic [1:0] OFS_DIR   = 2'd2;
    localparam logic [1:0] OFS_RSVD  = 2'd3;

    typedef enum logic [1:0] {
        SRC_INPUT = 2'd0,
        SRC_LATCH = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_PWM   = 2'd3
    } drv_src_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_INPUT,
        SEL_DIR,
        SEL_RSVD
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    // priority: PWM, then timer (only where wired), then software bit
    function automatic drv_src_e resolve_src(input logic pwm_on,
                                             input logic tmr_on,
                                             input logic dir_bit);
        if (pwm_on)       return SRC_PWM;
        else if (tmr_on)  return SRC_TIMER;
        else if (dir_bit) return SRC_LATCH;
        else              return SRC_INPUT;
    endfunction

    function automatic pin_drv_t drive_of(input drv_src_e src,
                                          input logic pwm_v,
                                          input logic tmr_v,
                                          input logic latch_v);
        pin_drv_t d;
        d.oe = (src != SRC_INPUT);
        unique case (src)
            SRC_PWM:   d.val = pwm_v;
            SRC_TIMER: d.val = tmr_v;
            SRC_LATCH: d.val = latch_v;
            default:   d.val = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= raw_in[i];
                stage2_q <= stage1_q;
            end
        end
        assign sync_out[i] = stage2_q;
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ovr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int TMR_CH = WIDTH / 2
) (
    input  logic [WIDTH-1:0]  dir_bits,
    input  logic [WIDTH-1:0]  latch_bits,
    input  logic [WIDTH-1:0]  pwm_en,
    input  logic [WIDTH-1:0]  pwm_val,
    input  logic [TMR_CH-1:0] tmr_oc_en,
    input  logic [TMR_CH-1:0] tmr_oc_val,
    output logic [WIDTH-1:0]  oe,
    output logic [WIDTH-1:0]  out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_drv_t drv;
        if ((i % 2) == 0) begin : g_even
            always_comb drv = drive_of(
                resolve_src(pwm_en[i], tmr_oc_en[i/2], dir_bits[i]),
                pwm_val[i], tmr_oc_val[i/2], latch_bits[i]);
        end else begin : g_odd
            always_comb drv = drive_of(
                resolve_src(pwm_en[i], 1'b0, dir_bits[i]),
                pwm_val[i], 1'b0, latch_bits[i]);
        end
        assign oe[i]  = drv.oe;
        assign out[i] = drv.val;
    end
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
    import gpio_ovr_pkg::*;
#(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0290
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pad_sync,
    input  logic [WIDTH-1:0]  oe_eff,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  latch_q
);
    reg_sel_e sel;
    logic     in_window;

    assign in_window = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

    always_comb begin
        sel = SEL_NONE;
        if (in_window) begin
            unique case (addr[1:0])
                OFS_DATA:  sel = SEL_DATA;
                OFS_INPUT: sel = SEL_INPUT;
                OFS_DIR:   sel = SEL_DIR;
                OFS_RSVD:  sel = SEL_RSVD;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            latch_q <= '0;
        end else if (we) begin
            if (sel == SEL_DIR)  dir_q   <= wdata;
            if (sel == SEL_DATA) latch_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA:  rdata = (latch_q & oe_eff) | (pad_sync & ~oe_eff);
            SEL_INPUT: rdata = pad_sync;
            SEL_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0290,
    localparam int               TMR_CH    = WIDTH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic [WIDTH-1:0]  pwm_en,
    input  logic [WIDTH-1:0]  pwm_val,
    input  logic [TMR_CH-1:0] tmr_oc_en,
    input  logic [TMR_CH-1:0] tmr_oc_val,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out
);
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;

    gpio_in_sync #(.WIDTH(WIDTH)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pad_in),
        .sync_out (pad_sync)
    );

    gpio_bus_regs #(
        .WIDTH     (WIDTH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pad_sync (pad_sync),
        .oe_eff   (pad_oe),
        .rdata    (bus_rdata),
        .dir_q    (dir_q),
        .latch_q  (latch_q)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .TMR_CH(TMR_CH)) mux_i (
        .dir_bits   (dir_q),
        .latch_bits (latch_q),
        .pwm_en     (pwm_en),
        .pwm_val    (pwm_val),
        .tmr_oc_en  (tmr_oc_en),
        .tmr_oc_val (tmr_oc_val),
        .oe         (pad_oe),
        .out        (pad_out)
    );
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0290,
    parameter int                TMR_CH    = WIDTH / 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pwm_en,
    input logic [WIDTH-1:0]  pwm_val,
    input logic [TMR_CH-1:0] tmr_oc_en,
    input logic [TMR_CH-1:0] tmr_oc_val,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out
);
    localparam logic [ADDR_W-1:0] IN_ADDR   = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RSVD_ADDR = BASE_ADDR + ADDR_W'(3);

    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                live_cnt <= 2'd0;
        else if (live_cnt != 3) live_cnt <= live_cnt + 2'd1;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        p_pwm_wins_r4: assert property (@(posedge clk) disable iff (rst)
            pwm_en[i] |-> (pad_oe[i] && (pad_out[i] == pwm_val[i])));
        if ((i % 2) == 0) begin : g_even
            p_timer_drive_r5: assert property (@(posedge clk) disable iff (rst)
                (!pwm_en[i] && tmr_oc_en[i/2]) |->
                    (pad_oe[i] && (pad_out[i] == tmr_oc_val[i/2])));
        end
    end

    p_input_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == IN_ADDR && live_cnt >= 2) |-> (bus_rdata == $past(pad_in, 2)));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RSVD_ADDR) |-> (bus_rdata == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:2] != BASE_ADDR[ADDR_W-1:2]) |-> (bus_rdata == '0));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
    .WIDTH     (WIDTH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .TMR_CH    (TMR_CH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pwm_en     (pwm_en),
    .pwm_val    (pwm_val),
    .tmr_oc_en  (tmr_oc_en),
    .tmr_oc_val (tmr_oc_val),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 16;
    localparam int TC = W / 2;
    localparam logic [AW-1:0] BASE = 16'h0290;
    localparam logic [AW-1:0] A_DATA = BASE;
    localparam logic [AW-1:0] A_IN   = BASE + 16'd1;
    localparam logic [AW-1:0] A_DIR  = BASE + 16'd2;
    localparam logic [AW-1:0] A_RSVD = BASE + 16'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pwm_en = '0;
    logic [W-1:0]  pwm_val = '0;
    logic [TC-1:0] tmr_oc_en = '0;
    logic [TC-1:0] tmr_oc_val = '0;
    logic [W-1:0]  pad_oe;
    logic [W-1:0]  pad_out;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model state, built from bus writes and the requirements
    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_latch = '0;
    logic [W-1:0] m_s1 = '0;
    logic [W-1:0] m_s2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ovr_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pwm_en(pwm_en), .pwm_val(pwm_val), .tmr_oc_en(tmr_oc_en),
        .tmr_oc_val(tmr_oc_val), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // two edges of delay on pad levels (R8)
    always @(posedge clk) begin
        if (rst) begin m_s1 <= '0; m_s2 <= '0; end
        else begin m_s1 <= pad_in; m_s2 <= m_s1; end
    end

    function automatic logic [W-1:0] exp_oe();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++)
            r[i] = pwm_en[i] | ((i % 2 == 0) ? tmr_oc_en[i/2] : 1'b0) | m_dir[i];
        return r;
    endfunction

    function automatic logic [W-1:0] exp_out();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (pwm_en[i])                           r[i] = pwm_val[i];
            else if (i % 2 == 0 && tmr_oc_en[i/2])   r[i] = tmr_oc_val[i/2];
            else if (m_dir[i])                       r[i] = m_latch[i];
            else                                     r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_data();
        logic [W-1:0] oe;
        oe = exp_oe();
        return (m_latch & oe) | (m_s2 & ~oe);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        if (a == A_DIR)  m_dir   = d;
        if (a == A_DATA) m_latch = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_pins(input string req);
        #1;
        check({req, " oe"}, pad_oe, exp_oe());
        check({req, " out"}, pad_out, exp_out());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_DIR, v);  check("R1 dir", v, 8'h00);
        rd(A_DATA, v); check("R1 data", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);

        // R2 direction register
        wr(A_DIR, 8'hA5); rd(A_DIR, v); check("R2 dir", v, 8'hA5);
        // R3 software direction drives latch
        wr(A_DATA, 8'h3C); check_pins("R3");
        wr(A_DIR, 8'h5A);  check_pins("R3");

        // R4 PWM wins over timer and direction bit
        @(negedge clk);
        wr(A_DIR, 8'h00);
        pwm_en = 8'hFF; pwm_val = 8'h96; tmr_oc_en = 4'hF; tmr_oc_val = 4'h0;
        check_pins("R4");
        // R5 timer on even pins only
        pwm_en = 8'h00; tmr_oc_val = 4'b1010;
        check_pins("R5");
        check("R5 oe even", pad_oe, 8'h55);
        check("R5 out even", pad_out, 8'h44);
        tmr_oc_en = '0;

        // R11 latch loaded while input, visible once output
        wr(A_DIR, 8'h00);
        wr(A_DATA, 8'hC3);
        check("R11 hidden", pad_out, 8'h00);
        wr(A_DIR, 8'hFF);
        check("R11 shown", pad_out, 8'hC3);

        // R8 synchronizer latency, R7 input register
        @(negedge clk) pad_in = 8'h0F;
        repeat (3) @(negedge clk);
        pad_in = 8'hF0;
        @(negedge clk); rd(A_IN, v); check("R8 one edge", v, 8'h0F);
        @(negedge clk); rd(A_IN, v); check("R8 two edges", v, 8'hF0);
        check("R7 input", v, 8'hF0);
        // R6 data read: all outputs -> latch; half inputs -> mix
        rd(A_DATA, v); check("R6 outputs", v, 8'hC3);
        wr(A_DIR, 8'h0F); rd(A_DATA, v); check("R6 mixed", v, 8'hF3);

        // R9 reserved location
        wr(A_RSVD, 8'hFF);
        rd(A_RSVD, v); check("R9 rsvd", v, 8'h00);
        rd(A_DIR, v);  check("R9 dir kept", v, 8'h0F);
        rd(A_DATA, v); check("R9 latch kept", v, exp_data());
        // R10 unmapped
        wr(16'h0294, 8'hFF); wr(16'h0192, 8'hFF);
        rd(16'h0294, v); check("R10 unmapped", v, 8'h00);
        rd(16'h1292, v); check("R10 unmapped hi", v, 8'h00);
        rd(A_DIR, v);    check("R10 dir kept", v, 8'h0F);

        // random mix
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            pwm_en     = 8'($urandom) & 8'($urandom);
            pwm_val    = 8'($urandom);
            tmr_oc_en  = 4'($urandom);
            tmr_oc_val = 4'($urandom);
            if ($urandom_range(0, 3) == 0) pad_in = 8'($urandom);
            case ($urandom_range(0, 3))
                0: wr(A_DIR, 8'($urandom));
                1: wr(A_DATA, 8'($urandom));
                default: ;
            endcase
            check_pins("R3 R4 R5 random");
            rd(A_DATA, v); check("R6 random", v, exp_data());
            rd(A_IN, v);   check("R7 random", v, m_s2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule